// File: doc/BRIEF.md
# Line REI Feedback Generator

This block converts the line-parity outcome of each received frame into the four-bit remote error indication carried back to the far end in the outbound frame's overhead. For every completed receive frame the framer presents two parity bytes: the one it expected and the one it received. The block compares them on a frame-complete strobe. It reduces the mismatch to an error value and holds that value. On the next transmit frame-start strobe, the held value is loaded into the outgoing field.

A small host register file sets the behaviour. One control bit selects how errors are reported. In count mode the field carries the number of mismatched parity bits. In flag mode it carries a single bit that says whether the frame had any mismatch. A second control bit takes the field away from the receive path and fills it from a host-written four-bit value. While the receive side reports loss of signal or loss of frame, the parity result is treated as meaningless and the automatic field is sent as zero.

Top module: `line_rei_gen`

## Requirements
- R1: After reset the outbound field is 0. The control register (address 0) and the host value register (address 1) both read back as 0, which selects count mode and automatic fill.
- R2: With control bit 0 (error type) cleared, a frame-complete strobe captures the number of bit positions in which the expected and received parity bytes differ. The next transmit frame-start places that count in the field.
- R3: In count mode the field spans 0 (identical parity bytes) to 8 (every parity bit wrong).
- R4: With control bit 0 set, the captured value is 1 if the parity bytes differ in any position and 0 if they are identical.
- R5: The field changes only on the clock edge that samples a transmit frame-start strobe. A receive result or a host write that arrives between two frame starts leaves the field being sent unchanged.
- R6: Without a new receive result, every later transmit frame-start sends the last captured value again.
- R7: With control bit 1 (host source) set, each transmit frame-start loads the field from the low four bits of address 1, whatever the receive results or loss indications are.
- R8: If loss of signal or loss of frame is asserted on a frame-complete strobe, the captured value is 0. If either is asserted on a transmit frame-start in automatic mode, the field sent is 0.
- R9: Address 0 reads back its two control bits in bits 1:0. Address 1 reads back its four-bit value in bits 3:0. All other bits and all other addresses read 0, and written bits that have no storage are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame_done | input | 1 | Receive frame complete, parity bytes valid |
| rx_par_exp | input | PAR_W | Expected line parity byte |
| rx_par_got | input | PAR_W | Received line parity byte |
| rx_los | input | 1 | Receive loss of signal |
| rx_lof | input | 1 | Receive loss of frame |
| tx_frame_start | input | 1 | Outbound frame start, field load point |
| host_wr | input | 1 | Host register write enable |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data for host_addr |
| rei_field | output | FIELD_W | Error field for the outbound overhead byte |

## Verification
The bench sweeps all 256 parity mismatch patterns in both reporting modes. A popcount that drops or double-counts a bit position fails here, and so does a flag that keys on a single bit instead of any bit. The all-ones pattern shows whether the count saturates or wraps at 8. Separate sequences land a receive result and host writes between two frame starts, which exposes a field that is not held until the insertion point. They also assert loss at capture time and at insertion time separately, so a design that checks loss at only one stage is caught. Host-source mode is run with loss asserted to confirm that the override is not masked.

// File: rtl/lrei_pkg.sv
package lrei_pkg;
   // host register map
   localparam int unsigned ADDR_CTRL    = 0;
   localparam int unsigned ADDR_HOSTVAL = 1;
   // control register bit positions
   localparam int unsigned CTL_FLAG_BIT = 0;   // 1 = per-frame flag, 0 = bit count
   localparam int unsigned CTL_SRC_BIT  = 1;   // 1 = host value, 0 = automatic
   localparam int unsigned CTL_BITS     = 2;
endpackage

// File: rtl/lrei_regs.sv
module lrei_regs
   import lrei_pkg::*;
#(
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned FIELD_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic               flag_mode,
   output logic               host_src,
   output logic [FIELD_W-1:0] host_val
);
   logic sel_ctrl, sel_val;
   assign sel_ctrl = (addr == ADDR_W'(ADDR_CTRL));
   assign sel_val  = (addr == ADDR_W'(ADDR_HOSTVAL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_mode <= 1'b0;
         host_src  <= 1'b0;
         host_val  <= '0;
      end else if (wr) begin
         if (sel_ctrl) begin
            flag_mode <= wdata[CTL_FLAG_BIT];
            host_src  <= wdata[CTL_SRC_BIT];
         end
         if (sel_val)
            host_val <= wdata[FIELD_W-1:0];
      end
   end

   // readback, widening generated per data width
   logic [DATA_W-1:0] ctrl_rd, val_rd;
   generate
      if (DATA_W > FIELD_W) begin : g_val_pad
         assign val_rd = {{(DATA_W-FIELD_W){1'b0}}, host_val};
      end else begin : g_val_full
         assign val_rd = host_val;
      end
      if (DATA_W > CTL_BITS) begin : g_ctl_pad
         assign ctrl_rd = {{(DATA_W-CTL_BITS){1'b0}}, host_src, flag_mode};
      end else begin : g_ctl_full
         assign ctrl_rd = {host_src, flag_mode};
      end
   endgenerate

   always_comb begin
      if (sel_ctrl)     rdata = ctrl_rd;
      else if (sel_val) rdata = val_rd;
      else              rdata = '0;
   end
endmodule

// File: rtl/lrei_calc.sv
module lrei_calc #(
   parameter int unsigned PAR_W   = 8,
   parameter int unsigned FIELD_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               done,
   input  logic [PAR_W-1:0]   par_exp,
   input  logic [PAR_W-1:0]   par_got,
   input  logic               loss,
   input  logic               flag_mode,
   output logic [FIELD_W-1:0] pend
);
   localparam int unsigned CNT_W = $clog2(PAR_W + 1);

   logic [PAR_W-1:0]   diff;
   logic [CNT_W-1:0]   cnt;
   logic [FIELD_W-1:0] value;

   assign diff = par_exp ^ par_got;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < PAR_W; i++)
         cnt = cnt + CNT_W'(diff[i]);
   end

   always_comb begin
      if (loss)           value = '0;
      else if (flag_mode) value = FIELD_W'(|diff);
      else                value = FIELD_W'(cnt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    pend <= '0;
      else if (done) pend <= value;
   end
endmodule

// File: rtl/lrei_insert.sv
module lrei_insert #(
   parameter int unsigned FIELD_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               host_src,
   input  logic               loss,
   input  logic [FIELD_W-1:0] host_val,
   input  logic [FIELD_W-1:0] auto_val,
   output logic [FIELD_W-1:0] field
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         field <= '0;
      else if (start) begin
         if (host_src)  field <= host_val;
         else if (loss) field <= '0;
         else           field <= auto_val;
      end
   end
endmodule

// File: rtl/line_rei_gen.sv
module line_rei_gen #(
   parameter int unsigned PAR_W   = 8,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_frame_done,
   input  logic [PAR_W-1:0]   rx_par_exp,
   input  logic [PAR_W-1:0]   rx_par_got,
   input  logic               rx_los,
   input  logic               rx_lof,
   input  logic               tx_frame_start,
   input  logic               host_wr,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic [FIELD_W-1:0] rei_field
);
   localparam int unsigned CNT_W = $clog2(PAR_W + 1);

   generate
      if (FIELD_W < CNT_W) begin : g_bad_field
         $error("FIELD_W too narrow for a full parity error count");
      end
      if (DATA_W < FIELD_W || DATA_W < 2) begin : g_bad_data
         $error("DATA_W must hold the host value and the control bits");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   logic               flag_mode, host_src, loss;
   logic [FIELD_W-1:0] host_val, pend_val;

   assign loss = rx_los | rx_lof;

   lrei_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr),
      .wdata(host_wdata), .rdata(host_rdata), .flag_mode(flag_mode),
      .host_src(host_src), .host_val(host_val)
   );

   lrei_calc #(.PAR_W(PAR_W), .FIELD_W(FIELD_W)) u_calc (
      .clk(clk), .rst_n(rst_n), .done(rx_frame_done), .par_exp(rx_par_exp),
      .par_got(rx_par_got), .loss(loss), .flag_mode(flag_mode), .pend(pend_val)
   );

   lrei_insert #(.FIELD_W(FIELD_W)) u_ins (
      .clk(clk), .rst_n(rst_n), .start(tx_frame_start), .host_src(host_src),
      .loss(loss), .host_val(host_val), .auto_val(pend_val), .field(rei_field)
   );
endmodule

// File: rtl/lrei_chk.sv
module lrei_chk #(
   parameter int unsigned PAR_W   = 8,
   parameter int unsigned FIELD_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rx_frame_done,
   input logic [PAR_W-1:0]   rx_par_exp,
   input logic [PAR_W-1:0]   rx_par_got,
   input logic               rx_los,
   input logic               rx_lof,
   input logic               tx_frame_start,
   input logic               host_src,
   input logic [FIELD_W-1:0] host_val,
   input logic [FIELD_W-1:0] pend_val,
   input logic [FIELD_W-1:0] rei_field
);
   // R5
   field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_frame_start |=> $stable(rei_field));

   // R7
   host_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_frame_start && host_src |=> rei_field == $past(host_val));

   // R8
   loss_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_frame_done && (rx_los || rx_lof) |=> pend_val == '0);

   // R8
   loss_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_frame_start && !host_src && (rx_los || rx_lof) |=> rei_field == '0);

   // R2
   clean_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_frame_done && rx_par_exp == rx_par_got |=> pend_val == '0);

   // R3
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_val <= FIELD_W'(PAR_W));
endmodule

bind line_rei_gen lrei_chk #(.PAR_W(PAR_W), .FIELD_W(FIELD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_frame_done(rx_frame_done),
   .rx_par_exp(rx_par_exp), .rx_par_got(rx_par_got), .rx_los(rx_los),
   .rx_lof(rx_lof), .tx_frame_start(tx_frame_start), .host_src(host_src),
   .host_val(host_val), .pend_val(pend_val), .rei_field(rei_field)
);

// File: tb/tb_line_rei_gen.sv
module tb_line_rei_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_frame_done = 1'b0;
   logic [7:0] rx_par_exp = '0, rx_par_got = '0;
   logic       rx_los = 1'b0, rx_lof = 1'b0;
   logic       tx_frame_start = 1'b0;
   logic       host_wr = 1'b0;
   logic [1:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic [3:0] rei_field;
   int checks = 0, errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   line_rei_gen dut (
      .clk(clk), .rst_n(rst_n), .rx_frame_done(rx_frame_done),
      .rx_par_exp(rx_par_exp), .rx_par_got(rx_par_got), .rx_los(rx_los),
      .rx_lof(rx_lof), .tx_frame_start(tx_frame_start), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .rei_field(rei_field)
   );

   function automatic int ones(input logic [7:0] v);
      int n = 0;
      for (int b = 0; b < 8; b++) if (v[b]) n++;
      return n;
   endfunction

   task automatic chk(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
      @(negedge clk); host_wr = 0;
   endtask

   task automatic hread(input string tag, input logic [1:0] a, input int expv);
      @(negedge clk); host_addr = a; #1;
      chk(tag, int'(host_rdata), expv);
   endtask

   task automatic rx(input logic [7:0] e, input logic [7:0] g, input logic los, input logic lof);
      @(negedge clk); rx_frame_done = 1; rx_par_exp = e; rx_par_got = g; rx_los = los; rx_lof = lof;
      @(negedge clk); rx_frame_done = 0; rx_los = 0; rx_lof = 0;
   endtask

   task automatic tx(input logic lof);
      @(negedge clk); tx_frame_start = 1; rx_lof = lof;
      @(negedge clk); tx_frame_start = 0; rx_lof = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 field", int'(rei_field), 0);
      hread("R1 ctrl", 2'd0, 0);
      hread("R1 hostval", 2'd1, 0);

      // R9 readback
      hwrite(2'd0, 8'hFC); hread("R9 ctrl drop", 2'd0, 0);
      hwrite(2'd0, 8'hFF); hread("R9 ctrl", 2'd0, 3);
      hwrite(2'd1, 8'hAB); hread("R9 hostval", 2'd1, 8'h0B);
      hwrite(2'd2, 8'hFF); hread("R9 unmapped", 2'd2, 0);
      hread("R9 unmapped3", 2'd3, 0);
      hwrite(2'd0, 8'h00);

      // R2/R3 count mode sweep
      for (int i = 0; i < 256; i++) begin
         logic [7:0] e;
         e = 8'((i * 73 + 5) & 255);
         rx(e, e ^ 8'(i), 0, 0);
         tx(0);
         chk("R2 count", int'(rei_field), ones(8'(i)));
         if (i == 255) chk("R3 max", int'(rei_field), 8);
         if (i == 0)   chk("R3 min", int'(rei_field), 0);
      end

      // R4 flag mode sweep
      hwrite(2'd0, 8'h01);
      for (int i = 0; i < 256; i++) begin
         logic [7:0] e;
         e = 8'((i * 151 + 9) & 255);
         rx(e, e ^ 8'(i), 0, 0);
         tx(0);
         chk("R4 flag", int'(rei_field), (i != 0) ? 1 : 0);
      end
      hwrite(2'd0, 8'h00);

      // R5/R6 insertion timing and hold
      rx(8'h00, 8'h0F, 0, 0); tx(0);
      chk("R5 first", int'(rei_field), 4);
      rx(8'h00, 8'hFF, 0, 0);
      chk("R5 mid-frame rx ignored", int'(rei_field), 4);
      hwrite(2'd1, 8'h05);
      chk("R5 mid-frame write ignored", int'(rei_field), 4);
      tx(0);
      chk("R5 next start", int'(rei_field), 8);
      tx(0);
      chk("R6 resend", int'(rei_field), 8);

      // R8 loss
      rx(8'h00, 8'hFF, 1, 0); tx(0);
      chk("R8 los capture", int'(rei_field), 0);
      rx(8'h3C, 8'hC3, 0, 1); tx(0);
      chk("R8 lof capture", int'(rei_field), 0);
      rx(8'h00, 8'h03, 0, 0); tx(1);
      chk("R8 lof insert", int'(rei_field), 0);
      tx(0);
      chk("R8 recover", int'(rei_field), 2);

      // R7 host source
      hwrite(2'd1, 8'h09); hwrite(2'd0, 8'h02);
      chk("R7 before start", int'(rei_field), 2);
      tx(0);
      chk("R7 host", int'(rei_field), 9);
      hwrite(2'd1, 8'h0F);
      chk("R7 held", int'(rei_field), 9);
      rx(8'h00, 8'h01, 0, 0);
      tx(1);
      chk("R7 host under loss", int'(rei_field), 15);
      hwrite(2'd0, 8'h00); tx(0);
      chk("R7 back to auto", int'(rei_field), 1);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule